// File: doc/BRIEF.md
# Byte-Wide SPI Master with Control, Status and Data Registers

This block is an SPI master that a small processor drives through three byte registers on a simple select/read/write bus. Software configures clock polarity, clock phase, bit order and SCK rate in the control register. A write to the data register then sends one byte on MOSI while the matching byte is collected from MISO. SCK is derived from the system clock by a prescaler with four rate codes and a double-speed option.

When the byte is done, a completion flag rises. Software can poll this flag, or it can raise an interrupt request. A data write made while a byte is still moving is refused, and it is recorded in a collision flag. Both flags clear in two steps: a status read that sees a flag set, followed by any access to the data register. Chip select is left to software.

Top module: `spi_master_regs`

## Requirements
- R1: Register select 0 is control, 1 is status, 2 is data; select 3 reads 0. After reset every register reads 0, SCK and MOSI are low and the interrupt request is low.
- R2: Control bits are: 7 interrupt enable, 6 enable, 5 LSB-first, 4 master, 3 polarity, 2 phase, 1:0 rate. The register reads back what was written.
- R3: Status bits are: 7 complete, 6 collision, 0 double speed. Only bit 0 is writable. Writes to bits 7 and 6 have no effect, and the other bits read 0.
- R4: With enable=1 and master=1, a data write while idle starts a transfer of exactly 16 SCK edges. The complete flag sets on the clock edge of the 16th SCK edge. MOSI is low whenever no transfer runs.
- R5: The SCK period in system clocks is 4, 16, 64 or 128 for rate 00, 01, 10 or 11. The double-speed bit halves it. The first SCK edge comes one half-period after the clock edge that takes the data write, and SCK changes only on half-period boundaries.
- R6: When idle, SCK sits at the polarity level: low for 0, high for 1.
- R7: With phase 0, the first bit is on MOSI from the start, MOSI changes on trailing edges, and MISO is sampled on leading edges. With phase 1, MOSI changes on leading edges from the second one on, and MISO is sampled on trailing edges.
- R8: LSB-first=0 sends and receives bit 7 first. LSB-first=1 sends bit 0 first, so 0xDE appears as 0,1,1,1,1,0,1,1.
- R9: After completion, reading the data register returns the byte assembled from the eight MISO samples.
- R10: A data write during a transfer sets the collision flag and leaves the running transfer's MOSI and SCK sequence and its received byte unchanged.
- R11: The complete and collision flags clear only after a status read that saw a flag set, followed by a data register access. A data access with no such prior status read leaves the flags set.
- R12: The interrupt request is high exactly while the complete flag and the interrupt enable are both 1.
- R13: With enable=0 or master=0, a data write starts nothing: SCK stays idle and the complete flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_sel | input | 2 | register select |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe (for flag-clear side effects) |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data for the selected register (combinational) |
| sck | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| irq | output | 1 | interrupt request |

## Verification
The bench predicts SCK, MOSI and the complete flag on every clock from a closed-form edge count. This exposes a phase or polarity error as a shifted or inverted waveform, and an off-by-one prescaler as edges landing a cycle early or late. It drives MISO from its own slave byte, so a design that sampled on the wrong edge or assembled bits in the wrong order would return a corrupted byte. A collision write is issued mid-transfer: a design that let it through would restart the shifter and break the waveform comparison. Flag clearing is tried both with and without the preceding status read; a design that cleared on any data access would drop the flag early.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int HALF_W = 7;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // System clocks per SCK half period
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
    logic [HALF_W-1:0] h;
    case (rate)
      2'd0:    h = HALF_W'(2);
      2'd1:    h = HALF_W'(8);
      2'd2:    h = HALF_W'(32);
      default: h = HALF_W'(64);
    endcase
    return dbl ? (h >> 1) : h;
  endfunction
endpackage

// File: rtl/spi_prescaler.sv
module spi_prescaler
  import spi_master_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= half - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] txd,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic              sample_ev,
  output logic              shift_ev,
  output logic [DATA_W-1:0] rx_data
);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [EDGE_W-1:0] edge_q;
  logic [BIT_W-1:0]  bit_q, pos;
  logic              lvl_q;
  logic [DATA_W-1:0] tx_q, rx_q, rx_next;
  logic              lead, last_edge;

  assign pos       = lsb_first ? bit_q : BIT_W'(DATA_W - 1) - bit_q;
  assign lead      = ~edge_q[0];
  assign last_edge = edge_q == EDGE_W'(EDGES - 1);
  assign sample_ev = busy && tick && (lead != cpha);
  assign shift_ev  = busy && tick && (lead == cpha) && edge_q != '0 && !last_edge;
  assign done      = busy && tick && last_edge && !abort;
  assign sck       = busy ? lvl_q : cpol;
  assign mosi      = busy ? tx_q[pos] : 1'b0;

  always_comb begin
    rx_next = rx_q;
    if (sample_ev) rx_next[pos] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      edge_q  <= '0;
      bit_q   <= '0;
      lvl_q   <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      rx_data <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      edge_q <= '0;
      bit_q  <= '0;
      lvl_q  <= cpol;
      tx_q   <= txd;
    end else if (busy && tick) begin
      lvl_q  <= ~lvl_q;
      edge_q <= edge_q + EDGE_W'(1);
      rx_q   <= rx_next;
      if (shift_ev) bit_q <= bit_q + BIT_W'(1);
      if (last_edge) begin
        busy    <= 1'b0;
        rx_data <= rx_next;
      end
    end
  end
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic              dbl_q, spif_q, wcol_q, arm_q;
  logic              ctrl_wr, stat_wr, stat_rd, data_wr, data_acc;
  logic              busy, tick, done, start, sample_ev, shift_ev;
  logic [DATA_W-1:0] rx_data;
  logic [HALF_W-1:0] half;

  assign ctrl_wr  = wr_en && reg_sel == REG_CTRL;
  assign stat_wr  = wr_en && reg_sel == REG_STAT;
  assign stat_rd  = rd_en && reg_sel == REG_STAT;
  assign data_wr  = wr_en && reg_sel == REG_DATA;
  assign data_acc = (wr_en || rd_en) && reg_sel == REG_DATA;
  assign start    = data_wr && ctrl_q.enable && ctrl_q.master && !busy;
  assign half     = half_period(ctrl_q.rate, dbl_q);
  assign irq      = spif_q && ctrl_q.irq_en;

  always_comb begin
    case (reg_sel)
      REG_CTRL: rdata = ctrl_q;
      REG_STAT: rdata = {spif_q, wcol_q, 5'b0, dbl_q};
      REG_DATA: rdata = rx_data;
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dbl_q  <= 1'b0;
      spif_q <= 1'b0;
      wcol_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata);
      if (stat_wr) dbl_q  <= wdata[0];
      if (stat_rd && (spif_q || wcol_q)) arm_q <= 1'b1;
      if (data_acc && arm_q) begin
        spif_q <= 1'b0;
        wcol_q <= 1'b0;
        arm_q  <= 1'b0;
      end
      if (data_wr && busy) wcol_q <= 1'b1;
      if (done)            spif_q <= 1'b1;
    end
  end

  spi_prescaler u_pre (
    .clk (clk),
    .rst_n (rst_n),
    .run (busy),
    .half (half),
    .tick (tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (!ctrl_q.enable),
    .txd       (wdata),
    .cpol      (ctrl_q.cpol),
    .cpha      (ctrl_q.cpha),
    .lsb_first (ctrl_q.lsb_first),
    .tick      (tick),
    .miso      (miso),
    .busy      (busy),
    .sck       (sck),
    .mosi      (mosi),
    .done      (done),
    .sample_ev (sample_ev),
    .shift_ev  (shift_ev),
    .rx_data   (rx_data)
  );
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic tick,
  input logic done,
  input logic spif,
  input logic wcol,
  input logic data_wr,
  input logic ctrl_wr,
  input logic spe,
  input logic cpol,
  input logic sck,
  input logic irq
);
  p_done_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> spif);

  p_sck_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !ctrl_wr) |=> $stable(sck));

  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctrl_wr) |=> (!busy -> sck == cpol));

  p_collision_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> wcol);

  p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done) || $past(ctrl_wr)));

  p_disabled_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !spe |=> !busy);
endmodule

bind spi_master_regs spi_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .tick    (tick),
  .done    (done),
  .spif    (spif_q),
  .wcol    (wcol_q),
  .data_wr (data_wr),
  .ctrl_wr (ctrl_wr),
  .spe     (ctrl_q.enable),
  .cpol    (ctrl_q.cpol),
  .sck     (sck),
  .irq     (irq)
);

// File: tb/sim_spi_master_regs.sv
module sim_spi_master_regs;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0, miso = 1'b0;
  logic [7:0] wdata = 8'h00, rdata;
  logic       sck, mosi, irq;
  int total = 0, bad = 0, cycles = 0;

  spi_master_regs u0 (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  // convention: called just after a negedge, returns just after a negedge
  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    reg_sel = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    reg_sel = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic int sys_per_half(input logic [1:0] rate, input logic dbl);
    int div = (rate == 2'd3) ? 128 : (4 << (2 * rate));
    if (dbl) div = div / 2;
    return div / 2;
  endfunction

  // one transfer compared on every clock against a closed-form edge count
  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input logic [7:0] ctl,
                      input logic dbl, input int collide_t);
    logic cpol = ctl[3], cpha = ctl[2], lsb = ctl[5];
    int h = sys_per_half(ctl[1:0], dbl);
    reg_sel = 2'd2; wdata = tx; wr_en = 1'b1;
    for (int t = 0; t <= 16 * h; t++) begin
      int n, idx, pos;
      @(negedge clk);
      wr_en = 1'b0; reg_sel = 2'd1;
      if (t == collide_t) begin reg_sel = 2'd2; wdata = ~tx; wr_en = 1'b1; end
      n   = t / h;
      idx = cpha ? ((n == 0) ? 0 : (n - 1) / 2) : n / 2;
      if (idx > 7) idx = 7;
      pos = lsb ? idx : 7 - idx;
      miso = slv[pos];
      #1;
      check("R5 R6 sck", int'(sck), (n < 16) ? int'(cpol ^ n[0]) : int'(cpol));
      check("R7 R8 mosi", int'(mosi), (n < 16) ? int'(tx[pos]) : 0);
      if (t != collide_t) check("R4 complete flag", int'(rdata[7]), (n >= 16) ? 1 : 0);
    end
    check("R12 irq", int'(irq), int'(ctl[7]));
    check("R10 collision flag", int'(rdata[6]), (collide_t >= 0) ? 1 : 0);
  endtask

  task automatic clear_flags(input logic [7:0] slv);
    logic [7:0] d;
    rreg(2'd1, d);
    rreg(2'd2, d);
    check("R9 R10 received byte", int'(d), int'(slv));
    rreg(2'd1, d);
    check("R11 flags cleared", int'(d[7:6]), 0);
    check("R12 irq after clear", int'(irq), 0);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_sel = 2'(a); #1;
      check("R1 reset register", int'(rdata), 0);
    end
    check("R1 reset sck", int'(sck), 0);
    check("R1 reset mosi", int'(mosi), 0);
    check("R1 reset irq", int'(irq), 0);

    // R2 control readback
    wreg(2'd0, 8'h51);
    rreg(2'd0, d); check("R2 control readback", int'(d), 8'h51);
    // R3 status: only double-speed writable
    wreg(2'd1, 8'hC1);
    rreg(2'd1, d); check("R3 status write", int'(d), 8'h01);
    wreg(2'd1, 8'h00);
    rreg(2'd1, d); check("R3 status clear dbl", int'(d), 8'h00);

    // main modes
    xfer(8'hDE, 8'h35, 8'h51, 1'b0, -1); clear_flags(8'h35);   // mode 0, /16
    wreg(2'd0, 8'h54);
    xfer(8'hA7, 8'hC2, 8'h54, 1'b0, -1); clear_flags(8'hC2);   // phase 1
    wreg(2'd0, 8'h58);
    xfer(8'h3C, 8'h81, 8'h58, 1'b0, -1); clear_flags(8'h81);   // polarity 1
    wreg(2'd0, 8'h71);
    xfer(8'hDE, 8'h6B, 8'h71, 1'b0, -1); clear_flags(8'h6B);   // R8 LSB first
    wreg(2'd0, 8'h53);
    xfer(8'hDE, 8'h0F, 8'h53, 1'b0, -1); clear_flags(8'h0F);   // R5 /128
    wreg(2'd1, 8'h01);
    wreg(2'd0, 8'h52);
    xfer(8'h96, 8'hF0, 8'h52, 1'b1, -1); clear_flags(8'hF0);   // R5 /64 halved
    wreg(2'd0, 8'h7C);
    xfer(8'h01, 8'h80, 8'h7C, 1'b1, -1); clear_flags(8'h80);   // R5 /4 halved, all modes set
    wreg(2'd1, 8'h00);

    // R12 interrupt enable
    wreg(2'd0, 8'hD0);
    xfer(8'h5A, 8'hA5, 8'hD0, 1'b0, -1); clear_flags(8'hA5);

    // R10 collision mid-transfer
    wreg(2'd0, 8'h51);
    xfer(8'hC3, 8'h17, 8'h51, 1'b0, 37); clear_flags(8'h17);

    // R11 data access without prior status read keeps flags
    xfer(8'h11, 8'h22, 8'h51, 1'b0, -1);
    rreg(2'd2, d); check("R9 data before clear", int'(d), 8'h22);
    rreg(2'd1, d); check("R11 flag kept without status read", int'(d[7]), 1);
    rreg(2'd2, d);
    rreg(2'd1, d); check("R11 flag cleared after sequence", int'(d[7]), 0);

    // R13 enable clear / master clear: no transfer
    wreg(2'd0, 8'h19);
    wreg(2'd2, 8'hFF);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); reg_sel = 2'd1; #1;
      check("R13 disabled sck idle", int'(sck), 1);
      check("R13 disabled no complete", int'(rdata[7]), 0);
    end
    wreg(2'd0, 8'h41);
    wreg(2'd2, 8'hFF);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); reg_sel = 2'd1; #1;
      check("R13 slave no sck", int'(sck), 0);
      check("R13 slave no complete", int'(rdata[7]), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule